// File: doc/BRIEF.md
# SPI master timing engine

This block drives one SPI link as a master, one frame at a time. It produces the serial clock, a set of chip-select lines and the outgoing data bit, and it samples the incoming data bit. All timing derives from the functional clock. A power-of-two prescaler scales the clock. An 8-bit divider, offset by two, sets the serial clock period. Three 8-bit guard fields set how long chip select leads the first clock edge, how long it trails the last clock edge, and how long the link idles between frames. The guard fields carry offsets of one, one and two prescaled cycles.

A controller sets the configuration inputs and holds them steady while frames run. It then hands over one word per frame through a valid/ready handshake. The engine returns the received word with a one-cycle valid pulse. A word offered during the last cycle of the idle gap starts the next frame at once, so back-to-back frames keep the gap exact. A soft reset abandons any frame in progress and returns the engine to idle.

Top module: `spi_frame_engine`

## Requirements
- R1: The serial clock period is (divider+2)·2^prescale functional cycles. The phase where the clock is 1 lasts the rounded-up half, and the phase where it is 0 lasts the rounded-down half. A frame of n bits has exactly 2n clock edges.
- R2: From the cycle chip select becomes active to the first clock edge is (lead field+1)·2^prescale cycles.
- R3: From the last clock edge to chip select going inactive is (trail field+1)·2^prescale cycles.
- R4: Chip select stays inactive for at least (gap field+2)·2^prescale cycles between frames. It stays inactive for exactly that long when the next word is already waiting.
- R5: The frame-size field holds the bit count minus one. Any value below 7 gives an 8-bit frame.
- R6: When chip select is inactive, the clock rests at the polarity bit. With phase 0, data is sampled on edges 1, 3, 5 and so on, and the first bit is on the output before edge 1. With phase 1, data changes on edges 1, 3, 5 and is sampled on edges 2, 4, 6.
- R7: With the LSB-first bit set, bit 0 of the word goes out first. Otherwise bit n-1 goes out first. The received word uses the same ordering and appears in bits n-1..0 of rx_data, with the upper bits zero.
- R8: During a frame, the selected chip-select line is driven to its own polarity bit (1 = active-high). Every other line, and every line when idle, sits at the inverse of its polarity bit.
- R9: rx_valid is a single-cycle pulse. It occurs once per frame, in the cycle in which chip select goes inactive.
- R10: tx_ready is high only while enable is 1 and the engine is idle or in the last gap cycle. With enable at 0, no frame starts.
- R11: One cycle after soft_rst is high, chip select is inactive, the clock is at its polarity level and no rx_valid occurs. The abandoned frame never completes, and soft_rst wins over a handshake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset: return to idle, drop the frame |
| enable | input | 1 | Master enable; frames start only when set |
| cfg_prescale | input | 3 | Power-of-two prescaler exponent |
| cfg_sckdiv | input | 8 | Clock divider (period = (value+2) prescaled cycles) |
| cfg_lead_dly | input | 8 | Select-to-first-edge delay minus one |
| cfg_trail_dly | input | 8 | Last-edge-to-deselect delay minus one |
| cfg_gap_dly | input | 8 | Inter-frame gap minus two |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Clock phase (0: sample on leading edge) |
| cfg_lsb_first | input | 1 | Shift order |
| cfg_framesz | input | 5 | Frame bit count minus one |
| cfg_cs_sel | input | 2 | Index of the chip select to drive |
| cfg_cs_pol | input | 4 | Per-line select polarity, 1 = active-high |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine accepts a word |
| tx_data | input | 32 | Word to transmit |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | 32 | Received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
A soft reset and a transmit handshake can fall in the same cycle. The bench provokes this by raising soft_rst and tx_valid together at a moment when tx_ready is high. It judges the result by watching that chip select never goes active and the clock never leaves its rest level for a long window afterwards. A second collision is the word handoff in the final gap cycle. Back-to-back frames exercise it, and they must show a gap of exactly the programmed length. After the reset tests, a fresh frame must return only its own data.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_TRAIL,
    ST_GAP
  } eng_state_t;

endpackage

// File: rtl/spi_interval_timer.sv
module spi_interval_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == '0);

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |-> (len != '0)); // R4

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int MAX_BITS = 32,
  parameter int NB_W     = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [NB_W-1:0]     nbits,
  input  logic                lsbf,
  input  logic                shift_out,
  input  logic                sample,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rx_word
);

  logic [MAX_BITS-1:0] tx_sr;
  logic [MAX_BITS-1:0] rx_sr;
  logic [NB_W-1:0]     pad;

  // unused high positions between the frame and the register top
  assign pad = NB_W'(MAX_BITS) - nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load) begin
      tx_sr <= lsbf ? tx_word : (tx_word << pad);
      rx_sr <= '0;
    end else begin
      if (shift_out) begin
        tx_sr <= lsbf ? (tx_sr >> 1) : (tx_sr << 1);
      end
      if (sample) begin
        rx_sr <= lsbf ? {miso, rx_sr[MAX_BITS-1:1]} : {rx_sr[MAX_BITS-2:0], miso};
      end
    end
  end

  assign mosi    = lsbf ? tx_sr[0] : tx_sr[MAX_BITS-1];
  assign rx_word = lsbf ? (rx_sr >> pad) : rx_sr;

  AST_SHIFT_SAMPLE_APART: assert property (@(posedge clk) disable iff (rst)
    !(shift_out && sample)); // R6

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int MAX_BITS = 32,
  parameter int PRE_W    = 3,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        soft_rst,
  input  logic                        enable,
  input  logic [PRE_W-1:0]            cfg_prescale,
  input  logic [DIV_W-1:0]            cfg_sckdiv,
  input  logic [DLY_W-1:0]            cfg_lead_dly,
  input  logic [DLY_W-1:0]            cfg_trail_dly,
  input  logic [DLY_W-1:0]            cfg_gap_dly,
  input  logic                        cfg_cpol,
  input  logic                        cfg_cpha,
  input  logic                        cfg_lsb_first,
  input  logic [$clog2(MAX_BITS)-1:0] cfg_framesz,
  input  logic [$clog2(NUM_CS)-1:0]   cfg_cs_sel,
  input  logic [NUM_CS-1:0]           cfg_cs_pol,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  input  logic [MAX_BITS-1:0]         tx_data,
  output logic                        rx_valid,
  output logic [MAX_BITS-1:0]         rx_data,
  output logic                        sck,
  output logic                        mosi,
  input  logic                        miso,
  output logic [NUM_CS-1:0]           cs_o
);

  localparam int FSZ_W  = $clog2(MAX_BITS);
  localparam int NB_W   = FSZ_W + 1;
  localparam int TG_W   = $clog2(2 * MAX_BITS);
  localparam int BASE_W = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 2;
  localparam int CNT_W  = BASE_W + (2 ** PRE_W) - 1;

  logic             rst_all;
  eng_state_t       state;
  logic             cs_act;
  logic             sck_ph;
  logic [TG_W-1:0]  tgl;
  logic             rx_valid_q;
  logic [MAX_BITS-1:0] rx_data_q;
  logic [MAX_BITS-1:0] rx_word;

  logic [NB_W-1:0]  nbits;
  logic [NB_W:0]    last_idx;
  logic             last;
  logic [CNT_W-1:0] per_len, hi_len, lo_len, lead_len, trail_len, gap_len, nxt_half;
  logic             t_load, done, tog, hs, nxt_lvl, shift_out, sample;
  logic [CNT_W-1:0] t_len;

  assign rst_all = rst | soft_rst;

  // frame length: field is count minus one, clamped to 8 bits minimum
  always_comb begin
    if (cfg_framesz < FSZ_W'(7)) nbits = NB_W'(8);
    else                         nbits = NB_W'(cfg_framesz) + NB_W'(1);
  end

  assign last_idx = {nbits, 1'b0} - (NB_W+1)'(1);
  assign last     = ((NB_W+1)'(tgl) == last_idx);

  // interval lengths in functional cycles
  assign per_len   = (CNT_W'(cfg_sckdiv) + CNT_W'(2)) << cfg_prescale;
  assign hi_len    = (per_len + CNT_W'(1)) >> 1;
  assign lo_len    = per_len >> 1;
  assign lead_len  = (CNT_W'(cfg_lead_dly) + CNT_W'(1)) << cfg_prescale;
  assign trail_len = (CNT_W'(cfg_trail_dly) + CNT_W'(1)) << cfg_prescale;
  assign gap_len   = (CNT_W'(cfg_gap_dly) + CNT_W'(2)) << cfg_prescale;

  assign tx_ready = enable && ((state == ST_IDLE) || ((state == ST_GAP) && done));
  assign hs       = tx_valid && tx_ready;
  assign tog      = done && ((state == ST_LEAD) || (state == ST_BITS));
  assign nxt_lvl  = (~sck_ph) ^ cfg_cpol;
  assign nxt_half = nxt_lvl ? hi_len : lo_len;

  always_comb begin
    t_load = 1'b0;
    t_len  = lead_len;
    if (hs) begin
      t_load = 1'b1;
      t_len  = lead_len;
    end else if (tog && !((state == ST_BITS) && last)) begin
      t_load = 1'b1;
      t_len  = nxt_half;
    end else if (tog) begin
      t_load = 1'b1;
      t_len  = trail_len;
    end else if ((state == ST_TRAIL) && done) begin
      t_load = 1'b1;
      t_len  = gap_len;
    end
  end

  // edge index tgl: even = leading edge, odd = trailing edge
  assign shift_out = tog && (cfg_cpha ? (!tgl[0] && (tgl != '0)) : (tgl[0] && !last));
  assign sample    = tog && (cfg_cpha ? tgl[0] : !tgl[0]);

  spi_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst_all),
    .load (t_load),
    .len  (t_len),
    .done (done)
  );

  spi_shift_unit #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_shift (
    .clk       (clk),
    .rst       (rst_all),
    .load      (hs),
    .tx_word   (tx_data),
    .nbits     (nbits),
    .lsbf      (cfg_lsb_first),
    .shift_out (shift_out),
    .sample    (sample),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      state      <= ST_IDLE;
      cs_act     <= 1'b0;
      sck_ph     <= 1'b0;
      tgl        <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (hs) begin
            state  <= ST_LEAD;
            cs_act <= 1'b1;
            tgl    <= '0;
            sck_ph <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (done) begin
            state  <= ST_BITS;
            sck_ph <= ~sck_ph;
            tgl    <= tgl + TG_W'(1);
          end
        end
        ST_BITS: begin
          if (done) begin
            sck_ph <= ~sck_ph;
            tgl    <= tgl + TG_W'(1);
            if (last) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (done) begin
            state      <= ST_GAP;
            cs_act     <= 1'b0;
            rx_valid_q <= 1'b1;
            rx_data_q  <= rx_word;
          end
        end
        ST_GAP: begin
          if (hs) begin
            state  <= ST_LEAD;
            cs_act <= 1'b1;
            tgl    <= '0;
            sck_ph <= 1'b0;
          end else if (done) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck      = sck_ph ^ cfg_cpol;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;

  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    assign cs_o[gi] = (cs_act && (cfg_cs_sel == gi)) ? cfg_cs_pol[gi] : ~cfg_cs_pol[gi];
  end

  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (rst)
    !cs_act |-> (sck == cfg_cpol)); // R6
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9
  AST_RX_AT_DESELECT: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!cs_act && $past(cs_act))); // R9
  AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (enable && !cs_act)); // R10
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!cs_act && !rx_valid)); // R11
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o ~^ cfg_cs_pol)); // R8

endmodule

// File: tb/spi_frame_engine_bench.sv
module spi_frame_engine_bench;

  localparam int NCS = 4;
  localparam int MB  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0;
  logic enable = 1'b0;
  logic [2:0] cfg_prescale = '0;
  logic [7:0] cfg_sckdiv = '0, cfg_lead_dly = '0, cfg_trail_dly = '0, cfg_gap_dly = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [4:0] cfg_framesz = 5'd7;
  logic [1:0] cfg_cs_sel = '0;
  logic [NCS-1:0] cfg_cs_pol = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [MB-1:0] tx_data = '0;
  logic rx_valid;
  logic [MB-1:0] rx_data;
  logic sck, mosi;
  logic miso = 1'b0;
  logic [NCS-1:0] cs_o;

  always #5 clk = ~clk;

  spi_frame_engine u_spi_frame_engine (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .enable(enable),
    .cfg_prescale(cfg_prescale), .cfg_sckdiv(cfg_sckdiv),
    .cfg_lead_dly(cfg_lead_dly), .cfg_trail_dly(cfg_trail_dly), .cfg_gap_dly(cfg_gap_dly),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_framesz(cfg_framesz), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_pol(cfg_cs_pol),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic int nbits_of(input int fs);
    return (fs < 7) ? 8 : fs + 1;
  endfunction
  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction
  function automatic int period_exp();
    return (int'(cfg_sckdiv) + 2) << cfg_prescale;
  endfunction
  function automatic int lead_exp();
    return (int'(cfg_lead_dly) + 1) << cfg_prescale;
  endfunction
  function automatic int trail_exp();
    return (int'(cfg_trail_dly) + 1) << cfg_prescale;
  endfunction
  function automatic int gap_exp();
    return (int'(cfg_gap_dly) + 2) << cfg_prescale;
  endfunction

  logic [31:0] txw [256];
  logic [31:0] sw  [256];
  int sent = 0, fr = 0;
  bit mon_en = 1, b2b = 0, have_off = 0;

  // monitor state
  int cyc = 0, t_on = 0, t_edge = 0, t_off = 0, tog = 0, sbit = 0, nb = 8;
  int k, d, e;
  bit prev_sck = 0, prev_act = 0, act_now, half_err = 0, cs_err = 0, idle_err = 0;
  logic [31:0] mos = '0;

  function automatic int pos_of(input int j);
    return cfg_lsb_first ? j : (nb - 1 - j);
  endfunction

  task automatic present();
    if (sbit < nb) miso = sw[fr & 255][pos_of(sbit)];
    sbit++;
  endtask

  always @(negedge clk) begin
    cyc++;
    act_now = (cs_o[cfg_cs_sel] == cfg_cs_pol[cfg_cs_sel]);
    if (!mon_en || rst) begin
      prev_sck = sck;
      prev_act = act_now;
    end else begin
      for (int i = 0; i < NCS; i++)
        if (i != int'(cfg_cs_sel) && cs_o[i] !== ~cfg_cs_pol[i]) cs_err = 1;
      if (!act_now && sck !== cfg_cpol) idle_err = 1;
      if (act_now && !prev_act) begin
        chk(!idle_err, "R6 idle clock level", 32'(idle_err), 0);
        idle_err = 0;
        if (have_off) begin
          d = cyc - t_off;
          e = gap_exp();
          if (b2b) chk(d == e, "R4 gap exact", d, e);
          else     chk(d >= e, "R4 gap minimum", d, e);
        end
        t_on = cyc; t_edge = cyc; tog = 0; sbit = 0; mos = '0; half_err = 0;
        nb = nbits_of(int'(cfg_framesz));
        if (!cfg_cpha) present();
      end
      if (act_now && sck !== prev_sck) begin
        k = tog;
        tog++;
        if (k == 0) chk(cyc - t_on == lead_exp(), "R2 lead delay", cyc - t_on, lead_exp());
        else begin
          d = cyc - t_edge;
          e = prev_sck ? ((period_exp() + 1) / 2) : (period_exp() / 2);
          if (d != e) half_err = 1;
        end
        t_edge = cyc;
        if (cfg_cpha ? (k % 2 == 1) : (k % 2 == 0)) mos[pos_of(k / 2)] = mosi;
        if (cfg_cpha ? (k % 2 == 0) : (k % 2 == 1)) present();
      end
      if (!act_now && prev_act) begin
        chk(tog == 2 * nb, (cfg_framesz < 7) ? "R5 short frame edge count" : "R1 edge count", tog, 2 * nb);
        chk(!half_err, "R1 half periods", 32'(half_err), 0);
        chk(cyc - t_edge == trail_exp(), "R3 trail delay", cyc - t_edge, trail_exp());
        chk(mos == (txw[fr & 255] & mask_of(nb)), "R6 R7 mosi word", mos, txw[fr & 255] & mask_of(nb));
        chk(rx_valid === 1'b1, "R9 rx pulse", 32'(rx_valid), 1);
        chk(rx_data == (sw[fr & 255] & mask_of(nb)), "R7 rx word", rx_data, sw[fr & 255] & mask_of(nb));
        chk(!cs_err, "R8 other selects", 32'(cs_err), 0);
        cs_err = 0;
        fr++;
        t_off = cyc;
        have_off = 1;
      end else if (rx_valid) begin
        chk(0, "R9 stray rx pulse", 1, 0);
      end
      prev_sck = sck;
      prev_act = act_now;
    end
  end

  task automatic send(input logic [31:0] d_tx, input logic [31:0] d_sl);
    txw[sent & 255] = d_tx;
    sw[sent & 255]  = d_sl;
    sent++;
    tx_data  = d_tx;
    tx_valid = 1'b1;
    while (1) begin
      if (tx_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (fr != sent) @(negedge clk);
    repeat (gap_exp() + 5) @(negedge clk);
  endtask

  task automatic set_cfg(input int p, input int dv, input int ld, input int tr, input int gp,
                         input bit pol, input bit pha, input bit lsb, input int fs,
                         input int sel, input logic [3:0] cpl);
    cfg_prescale = 3'(p); cfg_sckdiv = 8'(dv);
    cfg_lead_dly = 8'(ld); cfg_trail_dly = 8'(tr); cfg_gap_dly = 8'(gp);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    cfg_framesz = 5'(fs); cfg_cs_sel = 2'(sel); cfg_cs_pol = cpl;
    have_off = 0;
    repeat (3) @(negedge clk);
    prev_sck = sck;
    idle_err = 0;
  endtask

  task automatic batch(input int nfr, input bit back);
    b2b = back;
    for (int i = 0; i < nfr; i++) begin
      send($urandom, $urandom);
      if (!back) repeat ($urandom_range(0, 20)) @(negedge clk);
    end
    wait_idle();
  endtask

  initial begin
    int seen;
    void'($urandom(32'h5A17_C0DE));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(cs_o === ~cfg_cs_pol, "R8 reset selects", cs_o, ~cfg_cs_pol);
    chk(sck === cfg_cpol, "R6 reset clock", sck, cfg_cpol);
    chk(rx_valid === 1'b0, "R9 reset rx", rx_valid, 0);
    chk(tx_ready === 1'b0, "R10 ready without enable", tx_ready, 0);

    // enable low: offered word must not start a frame
    tx_valid = 1'b1; tx_data = 32'h55;
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (tx_ready !== 1'b0 || cs_o !== ~cfg_cs_pol || sck !== cfg_cpol) seen++;
    end
    tx_valid = 1'b0;
    chk(seen == 0, "R10 no frame while disabled", seen, 0);
    enable = 1'b1;
    @(negedge clk);

    // directed corners
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 7, 0, 4'b0000);     // fastest clock, mode 0
    batch(2, 1);
    set_cfg(0, 1, 3, 2, 1, 1, 1, 1, 15, 2, 4'b0100);    // odd period, mode 3, LSB first
    batch(3, 1);
    set_cfg(1, 2, 1, 1, 0, 0, 1, 0, 3, 1, 4'b1111);     // R5: size field 3 -> 8 bits
    batch(2, 1);
    set_cfg(7, 0, 0, 0, 0, 1, 0, 1, 7, 3, 4'b0011);     // largest prescaler
    batch(1, 1);
    set_cfg(0, 0, 255, 255, 255, 1, 0, 0, 31, 3, 4'b1010); // longest guards, 32 bits
    batch(2, 1);

    // random configurations
    for (int r = 0; r < 10; r++) begin
      set_cfg($urandom_range(0, 2), $urandom_range(0, 6), $urandom_range(0, 6),
              $urandom_range(0, 6), $urandom_range(0, 6), 1'($urandom), 1'($urandom),
              1'($urandom), $urandom_range(0, 31), $urandom_range(0, 3), 4'($urandom));
      batch(3, 1'($urandom));
    end

    // soft reset mid-frame
    set_cfg(0, 2, 1, 1, 1, 1, 0, 0, 15, 1, 4'b0010);
    mon_en = 0;
    tx_data = 32'hBEEF; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(cs_o === ~cfg_cs_pol, "R11 selects after soft reset", cs_o, ~cfg_cs_pol);
    chk(sck === cfg_cpol, "R11 clock after soft reset", sck, cfg_cpol);
    chk(rx_valid === 1'b0, "R11 no rx after soft reset", rx_valid, 0);
    seen = 0;
    repeat (200) begin
      @(negedge clk);
      if (rx_valid || cs_o !== ~cfg_cs_pol) seen++;
    end
    chk(seen == 0, "R11 abandoned frame stays quiet", seen, 0);

    // soft reset in the same cycle as a handshake
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; soft_rst = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0; soft_rst = 1'b0;
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (rx_valid || cs_o !== ~cfg_cs_pol || sck !== cfg_cpol) seen++;
    end
    chk(seen == 0, "R11 soft reset beats handshake", seen, 0);

    // recovery frame after the reset tests
    fr = sent;
    have_off = 0;
    prev_sck = sck;
    prev_act = 0;
    mon_en = 1;
    b2b = 0;
    send(32'h0000_A5C3, 32'h0000_3C5A);
    wait_idle();

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", fr, sent);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule